// File: doc/BRIEF.md
# LCD Controller Command Decoder

This block sits between a parallel host write port and the configuration state of a monochrome graphic LCD controller. Every byte the host writes carries a data/command select bit. Bytes marked as commands are decoded, and the block updates a bank of configuration registers: contrast, display start line, bias, segment remap, COM scan direction, power control, regulator ratio, display enable, inverse video and the all-pixels-on override. These registers drive the rest of the controller directly. Commands that act on state held elsewhere produce a one-cycle pulse instead. These are the column nibble, the page address, the read-modify-write entry and exit, and the indicator mode.

Two commands take the next command byte as their operand: the contrast command and the indicator-on command. The decoder keeps track of this pending state. A software reset command returns every register to its power-on value in a single cycle.

The input is a valid/ready stream. `in_ready` is always high, so the decoder takes one byte in every cycle that `in_valid` is high and never applies back-pressure. A byte counts as accepted on a rising clock edge where both `in_valid` and `in_ready` are high. Register outputs and pulses change on the edge that accepts the byte and are visible in the following cycle.

Top module: `lcd_cmd_decoder`

## Requirements
- R1: An accepted byte with `in_dc`=1 (display data), or a cycle with no accepted byte, leaves every register output unchanged, raises no pulse and does not disturb a pending operand.
- R2: After reset, contrast=0x20, start line=0, regulator ratio=3'b100, and power control, remap, bias, all-on, inverse, display-on and COM reverse are all 0. No pulse is raised.
- R3: The command 00100abc loads the regulator ratio with abc.
- R4: The command 00101abc loads power control. Bit 0 is the output buffer enable, bit 1 the regulator enable and bit 2 the booster enable.
- R5: The command 01xxxxxx loads the display start line with the low six bits.
- R6: The command 0x81 changes no output. The next command byte loads contrast with its low six bits.
- R7: The commands 0xA0/A1, 0xA2/A3, 0xA4/A5, 0xA6/A7 and 0xAE/AF load bit 0 into, respectively, segment remap, bias select (1 selects the lower-ratio bias), all-on, inverse and display-on.
- R8: The command 1100dxxx loads COM reverse with d (bit 3). The low three bits are ignored.
- R9: The command 0xE2 restores all registers to the R2 values. 0xE3 and every unlisted pattern (for example 0x80, 0xA8, 0xD5, 0xE1, 0xFx) change nothing.
- R10: The commands 0000nnnn, 0001nnnn and 1011nnnn raise a one-cycle `col_lo_pulse`, `col_hi_pulse` or `page_pulse` respectively, and `arg_nib` shows nnnn from that cycle on.
- R11: 0xE0 raises a one-cycle `rmw_enter_pulse` and 0xEE a one-cycle `rmw_exit_pulse`.
- R12: 0xAC raises `ind_pulse` with `ind_mode`=00. 0xAD raises nothing, and the next command byte raises `ind_pulse` with `ind_mode` equal to its bits 1:0.
- R13: While an operand is pending, the next command byte is used as the operand whatever its pattern (including 0xE2), and the pending state then clears.
- R14: `in_ready` is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Host byte valid |
| in_ready | output | 1 | Always high; decoder never stalls |
| in_dc | input | 1 | 0 = command byte, 1 = display data |
| in_byte | input | 8 | Host byte |
| contrast | output | 6 | Contrast level |
| start_line | output | 6 | Display start line |
| reg_ratio | output | 3 | Internal regulator ratio |
| pwr_ctrl | output | 3 | {booster, regulator, output buffer} enables |
| seg_remap | output | 1 | Column-to-segment reversal |
| bias_sel | output | 1 | Bias select |
| all_on | output | 1 | Force all pixels on |
| inverse | output | 1 | Inverse video |
| disp_on | output | 1 | Panel enable |
| com_rev | output | 1 | COM scan reversal |
| col_lo_pulse | output | 1 | Column low nibble command seen |
| col_hi_pulse | output | 1 | Column high nibble command seen |
| page_pulse | output | 1 | Page address command seen |
| arg_nib | output | 4 | Nibble of the last column/page command |
| rmw_enter_pulse | output | 1 | Read-modify-write entry |
| rmw_exit_pulse | output | 1 | Read-modify-write exit |
| ind_pulse | output | 1 | Indicator mode update |
| ind_mode | output | 2 | Indicator mode of the last update |

## Verification
The assertions check on every cycle that at most one pulse is high, and that idle cycles and data bytes leave every register and pending flag untouched. They also check that a software reset outside a pending operand yields the power-on values, that a pending operand always clears after the next command, and that the start-line and indicator-off commands take effect one cycle later. Only the bench's scenarios can show the two-byte sequences end to end: contrast loaded from the byte after 0x81, a reset byte swallowed as an operand, data bytes slipped between a command and its operand, and the full command map against a reference model over long mixed streams.

// File: rtl/lcd_cmd_pkg.sv
package lcd_cmd_pkg;

  localparam int BYTE_W     = 8;
  localparam int CONTRAST_W = 6;
  localparam int LINE_W     = 6;
  localparam int RATIO_W    = 3;
  localparam int PWR_W      = 3;
  localparam int NIB_W      = 4;
  localparam int IND_W      = 2;
  localparam int NUM_FLAGS  = 5;

  localparam logic [CONTRAST_W-1:0] POR_CONTRAST = 6'h20;
  localparam logic [LINE_W-1:0]     POR_LINE     = '0;
  localparam logic [RATIO_W-1:0]    POR_RATIO    = 3'b100;
  localparam logic [PWR_W-1:0]      POR_PWR      = '0;
  localparam logic [NUM_FLAGS-1:0]  POR_FLAGS    = '0;

  // Flag slots: 0 remap, 1 bias, 2 all-on, 3 inverse, 4 display-on
  typedef enum logic [2:0] {
    FL_REMAP = 3'd0,
    FL_BIAS  = 3'd1,
    FL_ALLON = 3'd2,
    FL_INV   = 3'd3,
    FL_DISP  = 3'd4
  } flag_e;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_COL_LO,
    OP_COL_HI,
    OP_RATIO,
    OP_PWR,
    OP_START,
    OP_CONTRAST_ARM,
    OP_FLAG,
    OP_IND_OFF,
    OP_IND_ARM,
    OP_PAGE,
    OP_COM,
    OP_RMW_IN,
    OP_RMW_OUT,
    OP_SWRST
  } op_e;

  typedef enum logic [1:0] {
    PEND_NONE,
    PEND_CONTRAST,
    PEND_IND
  } pend_e;

  typedef struct packed {
    logic [CONTRAST_W-1:0] contrast;
    logic [LINE_W-1:0]     start_line;
    logic [RATIO_W-1:0]    ratio;
    logic [PWR_W-1:0]      pwr;
    logic [NUM_FLAGS-1:0]  flags;
    logic                  com_rev;
  } cfg_t;

  localparam cfg_t CFG_POR = '{
    contrast:   POR_CONTRAST,
    start_line: POR_LINE,
    ratio:      POR_RATIO,
    pwr:        POR_PWR,
    flags:      POR_FLAGS,
    com_rev:    1'b0
  };

  // Sub-code in bits 3:1 of a 1010xxxx byte that selects each flag slot
  function automatic logic [2:0] flag_subcode(input int idx);
    return (idx == int'(FL_DISP)) ? 3'b111 : 3'(idx);
  endfunction

endpackage

// File: rtl/lcd_cmd_classify.sv
module lcd_cmd_classify
  import lcd_cmd_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  output op_e               op_o
);

  always_comb begin
    op_o = OP_NONE;
    casez (byte_i)
      8'b0000_????: op_o = OP_COL_LO;
      8'b0001_????: op_o = OP_COL_HI;
      8'b0010_0???: op_o = OP_RATIO;
      8'b0010_1???: op_o = OP_PWR;
      8'b01??_????: op_o = OP_START;
      8'b1000_0001: op_o = OP_CONTRAST_ARM;
      8'b1010_000?,
      8'b1010_001?,
      8'b1010_010?,
      8'b1010_011?,
      8'b1010_111?: op_o = OP_FLAG;
      8'b1010_1100: op_o = OP_IND_OFF;
      8'b1010_1101: op_o = OP_IND_ARM;
      8'b1011_????: op_o = OP_PAGE;
      8'b1100_????: op_o = OP_COM;
      8'b1110_0000: op_o = OP_RMW_IN;
      8'b1110_0010: op_o = OP_SWRST;
      8'b1110_1110: op_o = OP_RMW_OUT;
      default:      op_o = OP_NONE;
    endcase
  end

endmodule

// File: rtl/lcd_cmd_seq.sv
module lcd_cmd_seq
  import lcd_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic acc_i,
  input  op_e  op_i,
  output logic cmd_go_o,
  output logic opnd_contrast_o,
  output logic opnd_ind_o,
  output logic pending_o
);

  pend_e pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= PEND_NONE;
    end else if (acc_i) begin
      if (pend_q != PEND_NONE)            pend_q <= PEND_NONE;
      else if (op_i == OP_CONTRAST_ARM)   pend_q <= PEND_CONTRAST;
      else if (op_i == OP_IND_ARM)        pend_q <= PEND_IND;
    end
  end

  assign cmd_go_o        = acc_i && (pend_q == PEND_NONE);
  assign opnd_contrast_o = acc_i && (pend_q == PEND_CONTRAST);
  assign opnd_ind_o      = acc_i && (pend_q == PEND_IND);
  assign pending_o       = (pend_q != PEND_NONE);

endmodule

// File: rtl/lcd_cmd_regs.sv
module lcd_cmd_regs
  import lcd_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_go_i,
  input  logic              opnd_contrast_i,
  input  op_e               op_i,
  input  logic [BYTE_W-1:0] byte_i,
  output cfg_t              cfg_o
);

  cfg_t cfg_q;
  logic swrst;

  assign swrst = cmd_go_i && (op_i == OP_SWRST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.contrast <= POR_CONTRAST;
    end else if (swrst) begin
      cfg_q.contrast <= POR_CONTRAST;
    end else if (opnd_contrast_i) begin
      cfg_q.contrast <= byte_i[CONTRAST_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.start_line <= POR_LINE;
      cfg_q.ratio      <= POR_RATIO;
      cfg_q.pwr        <= POR_PWR;
      cfg_q.com_rev    <= 1'b0;
    end else if (swrst) begin
      cfg_q.start_line <= POR_LINE;
      cfg_q.ratio      <= POR_RATIO;
      cfg_q.pwr        <= POR_PWR;
      cfg_q.com_rev    <= 1'b0;
    end else if (cmd_go_i) begin
      unique case (op_i)
        OP_START: cfg_q.start_line <= byte_i[LINE_W-1:0];
        OP_RATIO: cfg_q.ratio      <= byte_i[RATIO_W-1:0];
        OP_PWR:   cfg_q.pwr        <= byte_i[PWR_W-1:0];
        OP_COM:   cfg_q.com_rev    <= byte_i[3];
        default:  ;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    logic hit;
    assign hit = cmd_go_i && (op_i == OP_FLAG) &&
                 (byte_i[3:1] == flag_subcode(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q.flags[i] <= POR_FLAGS[i];
      else if (swrst)  cfg_q.flags[i] <= POR_FLAGS[i];
      else if (hit)    cfg_q.flags[i] <= byte_i[0];
    end
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/lcd_cmd_pulses.sv
module lcd_cmd_pulses
  import lcd_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_go_i,
  input  logic             opnd_ind_i,
  input  op_e              op_i,
  input  logic [NIB_W-1:0] nib_i,
  output logic             col_lo_o,
  output logic             col_hi_o,
  output logic             page_o,
  output logic             rmw_in_o,
  output logic             rmw_out_o,
  output logic             ind_o,
  output logic [NIB_W-1:0] arg_o,
  output logic [IND_W-1:0] ind_mode_o
);

  logic hit_lo, hit_hi, hit_pg, hit_ioff;

  assign hit_lo   = cmd_go_i && (op_i == OP_COL_LO);
  assign hit_hi   = cmd_go_i && (op_i == OP_COL_HI);
  assign hit_pg   = cmd_go_i && (op_i == OP_PAGE);
  assign hit_ioff = cmd_go_i && (op_i == OP_IND_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_lo_o   <= 1'b0;
      col_hi_o   <= 1'b0;
      page_o     <= 1'b0;
      rmw_in_o   <= 1'b0;
      rmw_out_o  <= 1'b0;
      ind_o      <= 1'b0;
      arg_o      <= '0;
      ind_mode_o <= '0;
    end else begin
      col_lo_o  <= hit_lo;
      col_hi_o  <= hit_hi;
      page_o    <= hit_pg;
      rmw_in_o  <= cmd_go_i && (op_i == OP_RMW_IN);
      rmw_out_o <= cmd_go_i && (op_i == OP_RMW_OUT);
      ind_o     <= hit_ioff || opnd_ind_i;
      if (hit_lo || hit_hi || hit_pg) arg_o <= nib_i;
      if (hit_ioff)        ind_mode_o <= '0;
      else if (opnd_ind_i) ind_mode_o <= nib_i[IND_W-1:0];
    end
  end

endmodule

// File: rtl/lcd_cmd_decoder.sv
module lcd_cmd_decoder
  import lcd_cmd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  in_dc,
  input  logic [BYTE_W-1:0]     in_byte,
  output logic [CONTRAST_W-1:0] contrast,
  output logic [LINE_W-1:0]     start_line,
  output logic [RATIO_W-1:0]    reg_ratio,
  output logic [PWR_W-1:0]      pwr_ctrl,
  output logic                  seg_remap,
  output logic                  bias_sel,
  output logic                  all_on,
  output logic                  inverse,
  output logic                  disp_on,
  output logic                  com_rev,
  output logic                  col_lo_pulse,
  output logic                  col_hi_pulse,
  output logic                  page_pulse,
  output logic [NIB_W-1:0]      arg_nib,
  output logic                  rmw_enter_pulse,
  output logic                  rmw_exit_pulse,
  output logic                  ind_pulse,
  output logic [IND_W-1:0]      ind_mode
);

  op_e  op;
  logic acc, cmd_go, opnd_contrast, opnd_ind, pending;
  cfg_t cfg;

  assign in_ready = 1'b1;
  assign acc      = in_valid && in_ready && !in_dc;

  lcd_cmd_classify u_cls (
    .byte_i (in_byte),
    .op_o   (op)
  );

  lcd_cmd_seq u_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .acc_i           (acc),
    .op_i            (op),
    .cmd_go_o        (cmd_go),
    .opnd_contrast_o (opnd_contrast),
    .opnd_ind_o      (opnd_ind),
    .pending_o       (pending)
  );

  lcd_cmd_regs u_regs (
    .clk             (clk),
    .rst_n           (rst_n),
    .cmd_go_i        (cmd_go),
    .opnd_contrast_i (opnd_contrast),
    .op_i            (op),
    .byte_i          (in_byte),
    .cfg_o           (cfg)
  );

  lcd_cmd_pulses u_pls (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_go_i   (cmd_go),
    .opnd_ind_i (opnd_ind),
    .op_i       (op),
    .nib_i      (in_byte[NIB_W-1:0]),
    .col_lo_o   (col_lo_pulse),
    .col_hi_o   (col_hi_pulse),
    .page_o     (page_pulse),
    .rmw_in_o   (rmw_enter_pulse),
    .rmw_out_o  (rmw_exit_pulse),
    .ind_o      (ind_pulse),
    .arg_o      (arg_nib),
    .ind_mode_o (ind_mode)
  );

  assign contrast   = cfg.contrast;
  assign start_line = cfg.start_line;
  assign reg_ratio  = cfg.ratio;
  assign pwr_ctrl   = cfg.pwr;
  assign seg_remap  = cfg.flags[FL_REMAP];
  assign bias_sel   = cfg.flags[FL_BIAS];
  assign all_on     = cfg.flags[FL_ALLON];
  assign inverse    = cfg.flags[FL_INV];
  assign disp_on    = cfg.flags[FL_DISP];
  assign com_rev    = cfg.com_rev;

endmodule

// File: rtl/lcd_cmd_decoder_chk.sv
module lcd_cmd_decoder_chk
  import lcd_cmd_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_dc,
  input logic [BYTE_W-1:0]     in_byte,
  input logic                  pending,
  input logic [CONTRAST_W-1:0] contrast,
  input logic [LINE_W-1:0]     start_line,
  input logic [RATIO_W-1:0]    reg_ratio,
  input logic [PWR_W-1:0]      pwr_ctrl,
  input logic                  seg_remap,
  input logic                  bias_sel,
  input logic                  all_on,
  input logic                  inverse,
  input logic                  disp_on,
  input logic                  com_rev,
  input logic                  col_lo_pulse,
  input logic                  col_hi_pulse,
  input logic                  page_pulse,
  input logic                  rmw_enter_pulse,
  input logic                  rmw_exit_pulse,
  input logic                  ind_pulse,
  input logic [IND_W-1:0]      ind_mode
);

  logic cmd_acc;
  logic [5:0] pulses;
  assign cmd_acc = in_valid && !in_dc;
  assign pulses  = {col_lo_pulse, col_hi_pulse, page_pulse,
                    rmw_enter_pulse, rmw_exit_pulse, ind_pulse};

  AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulses)); // R10

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_acc |=> $stable(contrast) && $stable(start_line) && $stable(reg_ratio) &&
                 $stable(pwr_ctrl) && $stable(seg_remap) && $stable(bias_sel) &&
                 $stable(all_on) && $stable(inverse) && $stable(disp_on) &&
                 $stable(com_rev) && $stable(pending) && (pulses == 6'd0)); // R1

  AST_SWRST_POR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_acc && !pending && (in_byte == 8'hE2) |=>
      (contrast == 6'h20) && (start_line == 6'd0) && (reg_ratio == 3'b100) &&
      (pwr_ctrl == 3'd0) && !seg_remap && !bias_sel && !all_on && !inverse &&
      !disp_on && !com_rev); // R9

  AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_acc && pending |=> !pending); // R13

  AST_START_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_acc && !pending && (in_byte[7:6] == 2'b01) |=>
      (start_line == $past(in_byte[5:0]))); // R5

  AST_IND_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_acc && !pending && (in_byte == 8'hAC) |=>
      ind_pulse && (ind_mode == 2'b00)); // R12

endmodule

bind lcd_cmd_decoder lcd_cmd_decoder_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .in_valid        (in_valid),
  .in_dc           (in_dc),
  .in_byte         (in_byte),
  .pending         (pending),
  .contrast        (contrast),
  .start_line      (start_line),
  .reg_ratio       (reg_ratio),
  .pwr_ctrl        (pwr_ctrl),
  .seg_remap       (seg_remap),
  .bias_sel        (bias_sel),
  .all_on          (all_on),
  .inverse         (inverse),
  .disp_on         (disp_on),
  .com_rev         (com_rev),
  .col_lo_pulse    (col_lo_pulse),
  .col_hi_pulse    (col_hi_pulse),
  .page_pulse      (page_pulse),
  .rmw_enter_pulse (rmw_enter_pulse),
  .rmw_exit_pulse  (rmw_exit_pulse),
  .ind_pulse       (ind_pulse),
  .ind_mode        (ind_mode)
);

// File: tb/sim_lcd_cmd_decoder.sv
`timescale 1ns/1ps
module sim_lcd_cmd_decoder;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_dc = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic in_ready;
  logic [5:0] contrast, start_line;
  logic [2:0] reg_ratio, pwr_ctrl;
  logic seg_remap, bias_sel, all_on, inverse, disp_on, com_rev;
  logic col_lo_pulse, col_hi_pulse, page_pulse, rmw_enter_pulse, rmw_exit_pulse, ind_pulse;
  logic [3:0] arg_nib;
  logic [1:0] ind_mode;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  lcd_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dc(in_dc), .in_byte(in_byte), .contrast(contrast), .start_line(start_line),
    .reg_ratio(reg_ratio), .pwr_ctrl(pwr_ctrl), .seg_remap(seg_remap),
    .bias_sel(bias_sel), .all_on(all_on), .inverse(inverse), .disp_on(disp_on),
    .com_rev(com_rev), .col_lo_pulse(col_lo_pulse), .col_hi_pulse(col_hi_pulse),
    .page_pulse(page_pulse), .arg_nib(arg_nib), .rmw_enter_pulse(rmw_enter_pulse),
    .rmw_exit_pulse(rmw_exit_pulse), .ind_pulse(ind_pulse), .ind_mode(ind_mode)
  );

  // Behavioural reference model: integers, one state update per accepted byte
  int m_con, m_line, m_ratio, m_pwr, m_remap, m_bias, m_allon, m_inv, m_disp, m_com;
  int m_arg, m_imode, m_pend;
  int m_plo, m_phi, m_ppg, m_pri, m_pro, m_pind;

  task automatic model_por();
    m_con = 32; m_line = 0; m_ratio = 4; m_pwr = 0;
    m_remap = 0; m_bias = 0; m_allon = 0; m_inv = 0; m_disp = 0; m_com = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_por();
      m_arg = 0; m_imode = 0; m_pend = 0;
      m_plo = 0; m_phi = 0; m_ppg = 0; m_pri = 0; m_pro = 0; m_pind = 0;
    end else begin
      int b;
      b = int'(in_byte);
      m_plo = 0; m_phi = 0; m_ppg = 0; m_pri = 0; m_pro = 0; m_pind = 0;
      if (in_valid && !in_dc) begin
        if (m_pend == 1) begin
          m_con = b % 64; m_pend = 0;
        end else if (m_pend == 2) begin
          m_pind = 1; m_imode = b % 4; m_pend = 0;
        end else if (b < 16) begin
          m_plo = 1; m_arg = b;
        end else if (b < 32) begin
          m_phi = 1; m_arg = b - 16;
        end else if (b < 40) m_ratio = b - 32;
        else if (b < 48) m_pwr = b - 40;
        else if (b < 64) ;
        else if (b < 128) m_line = b - 64;
        else if (b == 129) m_pend = 1;
        else if (b == 160 || b == 161) m_remap = b - 160;
        else if (b == 162 || b == 163) m_bias = b - 162;
        else if (b == 164 || b == 165) m_allon = b - 164;
        else if (b == 166 || b == 167) m_inv = b - 166;
        else if (b == 174 || b == 175) m_disp = b - 174;
        else if (b == 172) begin m_pind = 1; m_imode = 0; end
        else if (b == 173) m_pend = 2;
        else if (b >= 176 && b < 192) begin m_ppg = 1; m_arg = b - 176; end
        else if (b >= 192 && b < 208) m_com = (b / 8) % 2;
        else if (b == 224) m_pri = 1;
        else if (b == 226) model_por();
        else if (b == 238) m_pro = 1;
      end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cmp_all(input string tag);
    chk(tag, "contrast",   int'(contrast),   m_con);
    chk(tag, "start_line", int'(start_line), m_line);
    chk(tag, "reg_ratio",  int'(reg_ratio),  m_ratio);
    chk(tag, "pwr_ctrl",   int'(pwr_ctrl),   m_pwr);
    chk(tag, "seg_remap",  int'(seg_remap),  m_remap);
    chk(tag, "bias_sel",   int'(bias_sel),   m_bias);
    chk(tag, "all_on",     int'(all_on),     m_allon);
    chk(tag, "inverse",    int'(inverse),    m_inv);
    chk(tag, "disp_on",    int'(disp_on),    m_disp);
    chk(tag, "com_rev",    int'(com_rev),    m_com);
  endtask

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6",  "contrast",   int'(contrast),   m_con);
      chk("R5",  "start_line", int'(start_line), m_line);
      chk("R3",  "reg_ratio",  int'(reg_ratio),  m_ratio);
      chk("R4",  "pwr_ctrl",   int'(pwr_ctrl),   m_pwr);
      chk("R7",  "flags",      int'({disp_on, inverse, all_on, bias_sel, seg_remap}),
          m_disp*16 + m_inv*8 + m_allon*4 + m_bias*2 + m_remap);
      chk("R8",  "com_rev",    int'(com_rev),    m_com);
      chk("R10", "col/page",   int'({col_lo_pulse, col_hi_pulse, page_pulse}),
          m_plo*4 + m_phi*2 + m_ppg);
      chk("R10", "arg_nib",    int'(arg_nib),    m_arg);
      chk("R11", "rmw",        int'({rmw_enter_pulse, rmw_exit_pulse}), m_pri*2 + m_pro);
      chk("R12", "ind_pulse",  int'(ind_pulse),  m_pind);
      chk("R12", "ind_mode",   int'(ind_mode),   m_imode);
      chk("R14", "in_ready",   int'(in_ready),   1);
    end
  end

  task automatic send(input logic dc, input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_dc = dc; in_byte = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset values
    chk("R2", "contrast", int'(contrast), 32);
    chk("R2", "reg_ratio", int'(reg_ratio), 4);
    chk("R2", "start_line", int'(start_line), 0);
    chk("R2", "pulses", int'({col_lo_pulse, col_hi_pulse, page_pulse,
        rmw_enter_pulse, rmw_exit_pulse, ind_pulse}), 0);

    // R3 R4 R5 R7 R8: set a broad configuration
    send(0, 8'h27); send(0, 8'h2D); send(0, 8'h7F); send(0, 8'hA1);
    send(0, 8'hA3); send(0, 8'hA5); send(0, 8'hA7); send(0, 8'hAF); send(0, 8'hCF);
    @(negedge clk); cmp_all("R7");
    chk("R8", "com_rev low bits ignored", int'(com_rev), 1);
    chk("R4", "pwr_ctrl", int'(pwr_ctrl), 5);

    // R1: data bytes that look like commands have no effect
    send(1, 8'hE2); send(1, 8'h40); send(1, 8'hA0); send(1, 8'h81);
    cmp_all("R1");
    chk("R1", "start_line held", int'(start_line), 63);

    // R6 with data bytes between command and operand (R1 keeps pending)
    send(0, 8'h81); cmp_all("R6");
    send(1, 8'h05); send(0, 8'hFF);
    @(negedge clk); chk("R6", "contrast", int'(contrast), 63);

    // R13: reset byte swallowed as operand
    send(0, 8'h81); send(0, 8'hE2);
    @(negedge clk); chk("R13", "contrast from E2", int'(contrast), 34);
    chk("R13", "disp_on kept", int'(disp_on), 1);

    // R12 indicator
    send(0, 8'hAD); send(0, 8'hE3);
    send(0, 8'hAC);
    send(0, 8'hAD); send(0, 8'h02);

    // R10 R11 pulses
    send(0, 8'h0A); send(0, 8'h1C); send(0, 8'hB8); send(0, 8'hE0); send(0, 8'hEE);

    // R9: ignored patterns then software reset
    send(0, 8'h80); send(0, 8'hA8); send(0, 8'hD5); send(0, 8'hE1);
    send(0, 8'hE3); send(0, 8'hF7); send(0, 8'h35);
    cmp_all("R9");
    send(0, 8'hE2);
    @(negedge clk); cmp_all("R9");
    chk("R9", "contrast por", int'(contrast), 32);

    // Back-to-back mixed stream
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      in_valid = ($urandom_range(0, 3) != 0);
      in_dc    = ($urandom_range(0, 4) == 0);
      in_byte  = 8'($urandom_range(0, 255));
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (3) @(negedge clk);
    cmp_all("R13");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule